// File: doc/BRIEF.md
# Compressed-State Branch-Link-Exchange Unit

This block is the execute-stage slice that resolves the branch family of the 16-bit compressed instruction state. It handles four forms. The first is the plain unconditional branch. The second is a long branch-with-link split over two halfwords. The third is a suffix of that pair that also switches to the 32-bit state. The fourth is a register-form branch-with-link-and-exchange found in the high-register operation group. The register file and fetch sit outside the block. The unit receives the opcode, the PC as read during execute (instruction address plus 4), the current link value and the operand selected by `rm_sel_o`. It returns write requests for the PC, the link register and the state bit, plus a refill request and an undefined-instruction trap.

The long branch passes its partial target from the prefix to the suffix through the link register. The suffix either stays in compressed state, or it word-aligns the target and leaves compressed state. A two-bit field chooses which. All requests are registered, so they appear on the outputs one clock after the opcode is presented with `valid_i`.

Top module: `cbr_link_xchg`

## Requirements
- R1: While `rst` is high at a clock edge, every request output (`pc_we_o`, `lr_we_o`, `tbit_we_o`, `flush_o`, `undef_o`) is low after that edge, even when `valid_i` is high.
- R2: An opcode with bits 15:13 = 111 and bits 12:11 = 00 requests a PC write of `pc_i` plus the sign-extended bits 10:0 shifted left by 1, together with a flush. It writes neither the link register nor the state bit.
- R3: An opcode with bits 15:11 = 11110 requests a link write of `pc_i` plus the sign-extended bits 10:0 shifted left by 12. It writes neither the PC nor the state bit, and it does not flush.
- R4: An opcode with bits 15:11 = 11111 requests a PC write of `lr_i` plus the zero-extended bits 10:0 shifted left by 1. It also requests a link write of (`pc_i` − 2) OR 1 and a flush. It does not write the state bit.
- R5: An opcode with bits 15:11 = 11101 and `arch_new_i` = 1 requests a PC write of (`lr_i` + zero-extended bits 10:0 shifted left by 1) with bits 1:0 cleared. It also requests a link write of (`pc_i` − 2) OR 1, a state-bit write of 0, and a flush.
- R6: An opcode with bits 15:11 = 11101 and `arch_new_i` = 0 raises `undef_o` and requests no PC, link or state-bit write and no flush.
- R7: An opcode with bits 15:10 = 010001, bits 9:8 = 11, bit 7 = 1 and `arch_new_i` = 1 requests a link write of (`pc_i` − 2) OR 1, a state-bit write of `rm_i[0]`, a PC write of `rm_i` with bit 0 cleared, and a flush.
- R8: `rm_sel_o` equals {opcode bit 6, opcode bits 5:3}, combinationally from `opcode_i`.
- R9: Requests appear on the clock edge after the opcode is presented. When `valid_i` is low, or the opcode matches none of R2 to R7, no request is raised. The cases that raise nothing include the form of R7 with `arch_new_i` = 0 and the form of R7 with bit 7 = 0.
- R10: All additions wrap modulo 2^32.
- R11: `undef_o` is never raised together with any write or flush, and `flush_o` is never raised without `pc_we_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Opcode present this cycle |
| opcode_i | input | 16 | Compressed-state instruction |
| pc_i | input | 32 | PC as read in execute (address + 4) |
| lr_i | input | 32 | Current link register value |
| rm_i | input | 32 | Register operand selected by `rm_sel_o` |
| arch_new_i | input | 1 | 1 = newer architecture version with exchange forms |
| rm_sel_o | output | 4 | Register index of the register-form source |
| pc_we_o | output | 1 | PC write request |
| pc_wdata_o | output | 32 | New PC value |
| lr_we_o | output | 1 | Link register write request |
| lr_wdata_o | output | 32 | New link value |
| tbit_we_o | output | 1 | State-bit write request |
| tbit_wdata_o | output | 1 | New state bit (1 = compressed) |
| flush_o | output | 1 | Pipeline refill request |
| undef_o | output | 1 | Undefined-instruction trap |

## Verification
The assertions on target bit 0 and on the odd link value assume that `pc_i` and `lr_i` are always halfword aligned. That holds for any link value a prefix produces. The bench therefore drives only even PC and link values, including values near the top and bottom of the address range that exercise the wrap. The operand `rm_i` is left unconstrained, because the register form clears its bit 0 itself. Both parities are driven to exercise the state-bit result.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;
    localparam int XLEN = 32;
    localparam int OFFW = 11;
    localparam int HALF = 16;
    localparam int RIDX = 4;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BRANCH,
        OP_PREFIX,
        OP_SUFFIX_STAY,
        OP_SUFFIX_XCHG,
        OP_REG_XCHG,
        OP_UNDEF
    } cbr_op_e;

    typedef struct packed {
        logic            pc_we;
        logic [XLEN-1:0] pc_val;
        logic            lr_we;
        logic [XLEN-1:0] lr_val;
        logic            t_we;
        logic            t_val;
        logic            flush;
        logic            undef;
    } cbr_res_t;

    // signed offset widened to the datapath, then scaled
    function automatic logic [XLEN-1:0] sext_shl(input logic [OFFW-1:0] off, input int unsigned sh);
        logic [XLEN-1:0] wide;
        wide = XLEN'($signed(off));
        return wide << sh;
    endfunction

    function automatic logic [XLEN-1:0] zext_shl(input logic [OFFW-1:0] off, input int unsigned sh);
        logic [XLEN-1:0] wide;
        wide = XLEN'(off);
        return wide << sh;
    endfunction

    // address of the following halfword, tagged as compressed state
    function automatic logic [XLEN-1:0] link_ret(input logic [XLEN-1:0] pc);
        logic [XLEN-1:0] nxt;
        nxt = pc - XLEN'(2);
        return {nxt[XLEN-1:1], 1'b1};
    endfunction
endpackage

// File: rtl/cbr_decode.sv
`timescale 1ns/1ps
module cbr_decode
    import cbr_pkg::*;
(
    input  logic [HALF-1:0] opcode,
    input  logic            arch_new,
    output cbr_op_e         op,
    output logic [OFFW-1:0] off,
    output logic [RIDX-1:0] rm_sel
);
    localparam logic [2:0] BR_GROUP = 3'b111;
    localparam logic [5:0] HI_GROUP = 6'b010001;
    localparam logic [1:0] HI_BX_OP = 2'b11;

    logic [1:0] hsel;

    always_comb begin
        off    = opcode[OFFW-1:0];
        rm_sel = {opcode[6], opcode[5:3]};
        hsel   = opcode[12:11];
        op     = OP_NONE;
        if (opcode[15:13] == BR_GROUP) begin
            case (hsel)
                2'b00:   op = OP_BRANCH;
                2'b10:   op = OP_PREFIX;
                2'b11:   op = OP_SUFFIX_STAY;
                default: op = arch_new ? OP_SUFFIX_XCHG : OP_UNDEF;
            endcase
        end else if (opcode[15:10] == HI_GROUP && opcode[9:8] == HI_BX_OP
                     && opcode[7] && arch_new) begin
            op = OP_REG_XCHG;
        end
    end
endmodule

// File: rtl/cbr_compute.sv
`timescale 1ns/1ps
module cbr_compute
    import cbr_pkg::*;
(
    input  cbr_op_e         op,
    input  logic [OFFW-1:0] off,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] lr,
    input  logic [XLEN-1:0] rm,
    output cbr_res_t        res
);
    logic [XLEN-1:0] near_tgt;
    logic [XLEN-1:0] far_hi;
    logic [XLEN-1:0] far_tgt;
    logic [XLEN-1:0] ret_addr;

    assign near_tgt = pc + sext_shl(off, 1);
    assign far_hi   = pc + sext_shl(off, 12);
    assign far_tgt  = lr + zext_shl(off, 1);
    assign ret_addr = link_ret(pc);

    always_comb begin
        res = '0;
        unique case (op)
            OP_BRANCH: begin
                res.pc_we  = 1'b1;
                res.pc_val = near_tgt;
                res.flush  = 1'b1;
            end
            OP_PREFIX: begin
                res.lr_we  = 1'b1;
                res.lr_val = far_hi;
            end
            OP_SUFFIX_STAY: begin
                res.pc_we  = 1'b1;
                res.pc_val = far_tgt;
                res.lr_we  = 1'b1;
                res.lr_val = ret_addr;
                res.flush  = 1'b1;
            end
            OP_SUFFIX_XCHG: begin
                res.pc_we  = 1'b1;
                res.pc_val = {far_tgt[XLEN-1:2], 2'b00};
                res.lr_we  = 1'b1;
                res.lr_val = ret_addr;
                res.t_we   = 1'b1;
                res.t_val  = 1'b0;
                res.flush  = 1'b1;
            end
            OP_REG_XCHG: begin
                res.pc_we  = 1'b1;
                res.pc_val = {rm[XLEN-1:1], 1'b0};
                res.lr_we  = 1'b1;
                res.lr_val = ret_addr;
                res.t_we   = 1'b1;
                res.t_val  = rm[0];
                res.flush  = 1'b1;
            end
            OP_UNDEF: res.undef = 1'b1;
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/cbr_link_xchg.sv
`timescale 1ns/1ps
module cbr_link_xchg
    import cbr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            valid_i,
    input  logic [15:0]     opcode_i,
    input  logic [31:0]     pc_i,
    input  logic [31:0]     lr_i,
    input  logic [31:0]     rm_i,
    input  logic            arch_new_i,
    output logic [3:0]      rm_sel_o,
    output logic            pc_we_o,
    output logic [31:0]     pc_wdata_o,
    output logic            lr_we_o,
    output logic [31:0]     lr_wdata_o,
    output logic            tbit_we_o,
    output logic            tbit_wdata_o,
    output logic            flush_o,
    output logic            undef_o
);
    cbr_op_e         dec_op;
    logic [OFFW-1:0] dec_off;
    cbr_res_t        nxt_res;
    cbr_res_t        res_q;

    cbr_decode u_dec (
        .opcode   (opcode_i),
        .arch_new (arch_new_i),
        .op       (dec_op),
        .off      (dec_off),
        .rm_sel   (rm_sel_o)
    );

    cbr_compute u_cmp (
        .op  (dec_op),
        .off (dec_off),
        .pc  (pc_i),
        .lr  (lr_i),
        .rm  (rm_i),
        .res (nxt_res)
    );

    always_ff @(posedge clk) begin
        if (rst || !valid_i) res_q <= '0;
        else                 res_q <= nxt_res;
    end

    assign pc_we_o      = res_q.pc_we;
    assign pc_wdata_o   = res_q.pc_val;
    assign lr_we_o      = res_q.lr_we;
    assign lr_wdata_o   = res_q.lr_val;
    assign tbit_we_o    = res_q.t_we;
    assign tbit_wdata_o = res_q.t_val;
    assign flush_o      = res_q.flush;
    assign undef_o      = res_q.undef;
endmodule

// File: rtl/cbr_link_xchg_chk.sv
`timescale 1ns/1ps
module cbr_link_xchg_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [15:0] opcode_i,
    input logic        arch_new_i,
    input logic        pc_we_o,
    input logic [31:0] pc_wdata_o,
    input logic        lr_we_o,
    input logic [31:0] lr_wdata_o,
    input logic        tbit_we_o,
    input logic        tbit_wdata_o,
    input logic        flush_o,
    input logic        undef_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(pc_we_o || lr_we_o || tbit_we_o || flush_o || undef_o));

    // R3
    prefix_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_i && opcode_i[15:11] == 5'b11110))
        |-> (lr_we_o && !pc_we_o && !flush_o && !tbit_we_o));

    // R5
    xchg_align_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_i && arch_new_i && opcode_i[15:11] == 5'b11101))
        |-> (pc_wdata_o[1:0] == 2'b00 && tbit_we_o && !tbit_wdata_o && flush_o));

    // R6
    old_arch_undef_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_i && !arch_new_i && opcode_i[15:11] == 5'b11101))
        |-> undef_o);

    // R4
    link_odd_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_we_o && lr_we_o) |-> (lr_wdata_o[0] && pc_wdata_o[0] == 1'b0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(valid_i))
        |-> !(pc_we_o || lr_we_o || tbit_we_o || flush_o || undef_o));

    // R11
    undef_alone_chk: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> !(pc_we_o || lr_we_o || tbit_we_o || flush_o));

    // R11
    flush_pc_chk: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> pc_we_o);
endmodule

bind cbr_link_xchg cbr_link_xchg_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .valid_i      (valid_i),
    .opcode_i     (opcode_i),
    .arch_new_i   (arch_new_i),
    .pc_we_o      (pc_we_o),
    .pc_wdata_o   (pc_wdata_o),
    .lr_we_o      (lr_we_o),
    .lr_wdata_o   (lr_wdata_o),
    .tbit_we_o    (tbit_we_o),
    .tbit_wdata_o (tbit_wdata_o),
    .flush_o      (flush_o),
    .undef_o      (undef_o)
);

// File: tb/cbr_link_xchg_bench.sv
`timescale 1ns/1ps
module cbr_link_xchg_bench;
    typedef struct packed {
        logic        pc_we;
        logic [31:0] pc_val;
        logic        lr_we;
        logic [31:0] lr_val;
        logic        t_we;
        logic        t_val;
        logic        flush;
        logic        undef;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [15:0] opcode_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] lr_i = '0;
    logic [31:0] rm_i = '0;
    logic        arch_new_i = 1'b1;
    logic [3:0]  rm_sel_o;
    logic        pc_we_o, lr_we_o, tbit_we_o, tbit_wdata_o, flush_o, undef_o;
    logic [31:0] pc_wdata_o, lr_wdata_o;

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    exp_t exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    cbr_link_xchg u_cbr_link_xchg (
        .clk(clk), .rst(rst), .valid_i(valid_i), .opcode_i(opcode_i),
        .pc_i(pc_i), .lr_i(lr_i), .rm_i(rm_i), .arch_new_i(arch_new_i),
        .rm_sel_o(rm_sel_o), .pc_we_o(pc_we_o), .pc_wdata_o(pc_wdata_o),
        .lr_we_o(lr_we_o), .lr_wdata_o(lr_wdata_o), .tbit_we_o(tbit_we_o),
        .tbit_wdata_o(tbit_wdata_o), .flush_o(flush_o), .undef_o(undef_o)
    );

    function automatic exp_t model(bit v, logic [15:0] opc, logic [31:0] pc,
                                   logic [31:0] lr, logic [31:0] rm, bit an);
        exp_t e = '0;
        logic [31:0] s1  = {{21{opc[10]}}, opc[10:0]} << 1;
        logic [31:0] s12 = {{21{opc[10]}}, opc[10:0]} << 12;
        logic [31:0] z1  = {21'd0, opc[10:0]} << 1;
        logic [31:0] ret = (pc - 32'd2) | 32'd1;
        if (!v) return e;
        if (opc[15:11] == 5'b11100) begin
            e.pc_we = 1; e.pc_val = pc + s1; e.flush = 1;
        end else if (opc[15:11] == 5'b11110) begin
            e.lr_we = 1; e.lr_val = pc + s12;
        end else if (opc[15:11] == 5'b11111) begin
            e.pc_we = 1; e.pc_val = lr + z1; e.lr_we = 1; e.lr_val = ret; e.flush = 1;
        end else if (opc[15:11] == 5'b11101) begin
            if (an) begin
                e.pc_we = 1; e.pc_val = (lr + z1) & 32'hFFFF_FFFC;
                e.lr_we = 1; e.lr_val = ret; e.t_we = 1; e.t_val = 0; e.flush = 1;
            end else e.undef = 1;
        end else if (opc[15:7] == 9'b010001111 && an) begin
            e.pc_we = 1; e.pc_val = rm & 32'hFFFF_FFFE;
            e.lr_we = 1; e.lr_val = ret; e.t_we = 1; e.t_val = rm[0]; e.flush = 1;
        end
        return e;
    endfunction

    task automatic issue(string tag, bit v, logic [15:0] opc, logic [31:0] pc,
                         logic [31:0] lr, logic [31:0] rm, bit an);
        @(negedge clk);
        valid_i = v; opcode_i = opc; pc_i = pc; lr_i = lr; rm_i = rm; arch_new_i = an;
        exp_q.push_back(model(v, opc, pc, lr, rm, an));
        tag_q.push_back(tag);
        #1;
        n_chk++;
        if (rm_sel_o !== {opc[6], opc[5:3]}) begin
            n_fail++;
            $display("FAIL R8 rm_sel actual=%h expected=%h", rm_sel_o, {opc[6], opc[5:3]});
        end
    endtask

    // monitor: pops one expected item per cycle, 5 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t  e = exp_q.pop_front();
                string t = tag_q.pop_front();
                exp_t  g = {pc_we_o, pc_wdata_o, lr_we_o, lr_wdata_o,
                            tbit_we_o, tbit_wdata_o, flush_o, undef_o};
                n_chk++;
                if (g !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", t, g, e);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset dominates a valid branch
        @(negedge clk);
        valid_i = 1; opcode_i = 16'hE005; pc_i = 32'h100;
        repeat (2) @(negedge clk);
        n_chk++;
        if ({pc_we_o, lr_we_o, tbit_we_o, flush_o, undef_o} !== 5'b0) begin
            n_fail++;
            $display("FAIL R1 actual=%b expected=00000",
                     {pc_we_o, lr_we_o, tbit_we_o, flush_o, undef_o});
        end
        valid_i = 0;
        rst = 0;

        issue("R2 fwd",       1, 16'hE005, 32'h0000_1000, 32'h0,         32'h0, 1);
        issue("R2 back",      1, 16'hE7FE, 32'h0000_1000, 32'h0,         32'h0, 1);
        issue("R10 br wrap",  1, 16'hE400, 32'h0000_0004, 32'h0,         32'h0, 1);
        issue("R3 prefix",    1, 16'hF012, 32'h0000_2004, 32'h0,         32'h0, 1);
        issue("R3 neg",       1, 16'hF7FF, 32'h0000_2004, 32'h0,         32'h0, 0);
        issue("R10 pre wrap", 1, 16'hF3FF, 32'hFFFF_FFF0, 32'h0,         32'h0, 1);
        issue("R4 stay",      1, 16'hF834, 32'h0000_2006, 32'h0001_4000, 32'h0, 1);
        issue("R10 sfx wrap", 1, 16'hFFFF, 32'h0000_0006, 32'hFFFF_FFFE, 32'h0, 0);
        issue("R5 xchg",      1, 16'hE835, 32'h0000_2006, 32'h0001_4000, 32'h0, 1);
        issue("R5 xchg2",     1, 16'hE802, 32'h0000_3002, 32'h0000_8002, 32'h0, 1);
        issue("R6 old",       1, 16'hE835, 32'h0000_2006, 32'h0001_4000, 32'h0, 0);
        issue("R7 reg thumb", 1, 16'h47C8, 32'h0000_4004, 32'h0,         32'h0000_9001, 1);
        issue("R7 reg arm",   1, 16'h47A0, 32'h0000_4004, 32'h0,         32'h0000_A002, 1);
        issue("R9 reg old",   1, 16'h47C8, 32'h0000_4004, 32'h0,         32'h0000_9001, 0);
        issue("R9 no H1",     1, 16'h4748, 32'h0000_4004, 32'h0,         32'h0000_9001, 1);
        issue("R9 other",     1, 16'h1234, 32'h0000_4004, 32'h0,         32'h0, 1);
        issue("R9 invalid",   0, 16'hE005, 32'h0000_1000, 32'h0,         32'h0, 1);
        issue("R11 idle",     0, 16'h0000, 32'h0,         32'h0,         32'h0, 1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule